// File: doc/BRIEF.md
# Injected Channel Group Sequencer

This block runs a secondary group of one to four analog channels that is converted apart from the main (regular) scan. It shares one converter with the regular scan. The regular side reports through `reg_busy` while it owns the converter and pulses `reg_pass_done` when it finishes a pass. The block only asks for the converter while `reg_busy` is low. A start that arrives while the regular side is busy is held, and the request goes out once the regular conversion ends.

A group can be started three ways. In normal mode the external trigger or the software start bit starts it. In auto mode the end of each regular pass starts it. In stepping mode each start converts only the next channel of the group. Each raw 12-bit result has the offset of its result slot subtracted. It is then stored as a signed 16-bit value, either right-justified or left-justified. A completion flag, with an optional interrupt, reports a finished group. All configuration and results go through a small register port.

The converter side uses a valid/ready pair. `conv_req` is the valid and `conv_gnt` is the ready. While `conv_req` waits for `conv_gnt`, `conv_ch` does not change. The request is withdrawn while `reg_busy` is high and raised again when `reg_busy` drops. At most one conversion is outstanding at any time. The result comes back on `res_valid`/`res_data` and is always accepted, with no back-pressure.

Top module: `inj_group_ctrl`

Register map (word address on `cfg_addr`):

| Address | Contents |
|---|---|
| 0 (control) | bit0 auto, bit1 stepping, bit2 interrupt enable, bit3 left-justify, bit4 software start |
| 1 (status) | bit0 completion flag; writing 1 to bit0 clears it |
| 2 (group) | four 5-bit channel slots, slot s (s = 1..4) at bits [5s-1:5s-5]; length N at bits [22:20] |
| 3..6 | offsets 1..4, 12 bits |
| 8..11 | results 1..4, 16 bits, read-only |

## Requirements
- R1: The group register accepts a write only when the length field [22:20] is 1 to 4. A write with a length of 0 or 5 to 7 leaves the whole register unchanged. After reset the register reads 0x00100000, which is length 1 with all slots 0.
- R2: A group of N channels takes its channels from slots 5-N through 4, in that order. The last channel converted is always slot 4. `conv_ch` presents each channel in turn.
- R3: The k-th channel converted in a group writes result register k (address 7+k). The other result registers keep their values.
- R4: A stored result is the raw value minus the offset of its slot, as a 13-bit signed number. With left-justify clear, it is sign-extended to 16 bits, so a negative difference reads as its 16-bit two's complement.
- R5: With left-justify set (control bit3), the stored result is the 13-bit signed difference shifted left by 3.
- R6: With auto mode set (control bit0), a pulse on `reg_pass_done` starts the whole group, and `ext_trig` starts nothing.
- R7: With stepping mode set (control bit1), each start converts exactly one channel, the next one in the group. After the last channel it wraps back to the first.
- R8: The completion flag (status bit0, `inj_eoc`) is set when the last channel of the group is stored, and not earlier. It stays set until 1 is written to status bit0. `inj_irq` is the flag ANDed with control bit2.
- R9: Writing 1 to control bit4 starts the group. The bit reads back as 1 until the converter grants the first request, and as 0 after that.
- R10: `conv_req` is never high while `reg_busy` is high. A start received while `reg_busy` is high raises the request after `reg_busy` falls.
- R11: While `conv_req` is high and `conv_gnt` is low, `conv_ch` holds its value. After a grant, no new request is made until `res_valid` returns.
- R12: A start received while a group is in progress is ignored. The group makes exactly N grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| ext_trig | input | 1 | External start pulse |
| reg_busy | input | 1 | Regular scan owns the converter |
| reg_pass_done | input | 1 | Regular pass finished, one-cycle pulse |
| conv_req | output | 1 | Converter request (valid) |
| conv_ch | output | 5 | Channel to convert |
| conv_gnt | input | 1 | Converter accepts request (ready) |
| res_valid | input | 1 | Raw result strobe |
| res_data | input | 12 | Raw conversion result |
| inj_eoc | output | 1 | Group completion flag |
| inj_irq | output | 1 | Completion interrupt |

## Verification
On every cycle, the assertions check several properties that hold from cycle to cycle. The stored length always stays between 1 and 4. The step index always stays inside the group. No request is made while the regular side is busy or while a conversion is outstanding. The channel on a stalled request does not change. Auto mode stays idle when it sees only an external trigger. The completion flag holds until it is cleared. Other behaviour can only be shown by the directed scenarios, because they need expected values built from the channel order and the offsets. These scenarios cover the slot-to-channel order for lengths 1, 3 and 4, the offset arithmetic in both justifications, including negative results, the stepping wrap, the software-start read-back and retriggers ignored during a group.

// File: rtl/inj_pkg.sv
package inj_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} inj_state_t;

  localparam int ADR_CTRL = 0;
  localparam int ADR_STAT = 1;
  localparam int ADR_SEQ  = 2;
  localparam int ADR_OFS  = 3;
  localparam int ADR_DAT  = 8;

  localparam int CB_AUTO = 0;
  localparam int CB_STEP = 1;
  localparam int CB_IRQ  = 2;
  localparam int CB_LEFT = 3;
  localparam int CB_SW   = 4;
endpackage

// File: rtl/inj_regs.sv
module inj_regs
  import inj_pkg::*;
#(
  parameter int CH_W  = 5,
  parameter int SLOTS = 4,
  parameter int RAW_W = 12,
  parameter int OUT_W = 16,
  parameter int AW    = 4,
  parameter int DW    = 32,
  localparam int LW   = $clog2(SLOTS) + 1,
  localparam int IW   = $clog2(SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output logic                   auto_mode,
  output logic                   step_mode,
  output logic                   irq_en,
  output logic                   left_just,
  output logic                   sw_start,
  output logic [LW-1:0]          seq_len,
  output logic [SLOTS*CH_W-1:0]  slots,
  output logic [SLOTS*RAW_W-1:0] ofs_flat,
  output logic                   seq_wr,
  output logic                   eoc,
  input  logic                   sw_clr,
  input  logic                   res_we,
  input  logic [IW-1:0]          res_sel,
  input  logic [OUT_W-1:0]       res_val,
  input  logic                   eoc_set
);
  logic [3:0]       mode_q;
  logic [LW-1:0]    new_len;
  logic             wr_ctrl, wr_stat;
  logic [RAW_W-1:0] ofs_q [SLOTS];
  logic [OUT_W-1:0] dat_q [SLOTS];
  logic             unused_wdata;

  assign unused_wdata = ^wdata;
  assign wr_ctrl = wr_en && (addr == AW'(ADR_CTRL));
  assign wr_stat = wr_en && (addr == AW'(ADR_STAT));
  assign new_len = wdata[SLOTS*CH_W +: LW];
  assign seq_wr  = wr_en && (addr == AW'(ADR_SEQ)) &&
                   (new_len != '0) && (new_len <= LW'(SLOTS));

  assign auto_mode = mode_q[CB_AUTO];
  assign step_mode = mode_q[CB_STEP];
  assign irq_en    = mode_q[CB_IRQ];
  assign left_just = mode_q[CB_LEFT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      sw_start <= 1'b0;
      eoc      <= 1'b0;
      seq_len  <= LW'(1);
      slots    <= '0;
    end else begin
      if (wr_ctrl) mode_q <= wdata[3:0];
      if (wr_ctrl && wdata[CB_SW]) sw_start <= 1'b1;
      else if (sw_clr)             sw_start <= 1'b0;
      if (eoc_set)                 eoc <= 1'b1;
      else if (wr_stat && wdata[0]) eoc <= 1'b0;
      if (seq_wr) begin
        seq_len <= new_len;
        slots   <= wdata[SLOTS*CH_W-1:0];
      end
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ofs_q[k] <= '0;
        dat_q[k] <= '0;
      end else begin
        if (wr_en && addr == AW'(ADR_OFS + k)) ofs_q[k] <= wdata[RAW_W-1:0];
        if (res_we && res_sel == IW'(k))      dat_q[k] <= res_val;
      end
    end
    assign ofs_flat[k*RAW_W +: RAW_W] = ofs_q[k];
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(ADR_CTRL)) rdata = DW'({sw_start, mode_q});
    if (addr == AW'(ADR_STAT)) rdata = DW'(eoc);
    if (addr == AW'(ADR_SEQ))  rdata = DW'({seq_len, slots});
    for (int k = 0; k < SLOTS; k++) begin
      if (addr == AW'(ADR_OFS + k)) rdata = DW'(ofs_q[k]);
      if (addr == AW'(ADR_DAT + k)) rdata = DW'(dat_q[k]);
    end
  end

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_len != '0) && (seq_len <= LW'(SLOTS)));  // R1
  AST_EOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    eoc && !(wr_stat && wdata[0]) |=> eoc);  // R8
endmodule

// File: rtl/inj_seq.sv
module inj_seq
  import inj_pkg::*;
#(
  parameter int CH_W  = 5,
  parameter int SLOTS = 4,
  localparam int LW   = $clog2(SLOTS) + 1,
  localparam int IW   = $clog2(SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  auto_mode,
  input  logic                  step_mode,
  input  logic                  sw_start,
  input  logic                  ext_trig,
  input  logic                  reg_pass_done,
  input  logic                  reg_busy,
  input  logic [LW-1:0]         seq_len,
  input  logic [SLOTS*CH_W-1:0] slots,
  input  logic                  seq_wr,
  output logic                  conv_req,
  output logic [CH_W-1:0]       conv_ch,
  input  logic                  conv_gnt,
  input  logic                  res_valid,
  output logic                  res_we,
  output logic [IW-1:0]         res_sel,
  output logic                  sw_clr,
  output logic                  eoc_set
);
  inj_state_t      state;
  logic [IW-1:0]   idx;
  logic [LW-1:0]   pos;
  logic            start, last;
  logic [CH_W-1:0] slot_a [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_unpack
    assign slot_a[s] = slots[s*CH_W +: CH_W];
  end

  // a group of N sits in the top N slots
  assign pos      = LW'(idx) + (LW'(SLOTS) - seq_len);
  assign conv_ch  = slot_a[pos[IW-1:0]];
  assign last     = (LW'(idx) == seq_len - LW'(1));
  assign start    = (auto_mode ? reg_pass_done : ext_trig) | sw_start;
  assign conv_req = (state == ST_REQ) && !reg_busy;
  assign sw_clr   = conv_req && conv_gnt;
  assign res_we   = (state == ST_WAIT) && res_valid && !seq_wr;
  assign res_sel  = idx;
  assign eoc_set  = res_we && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else if (seq_wr) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_REQ;
          if (!step_mode) idx <= '0;
        end
        ST_REQ: if (conv_req && conv_gnt) state <= ST_WAIT;
        ST_WAIT: if (res_valid) begin
          idx   <= last ? '0 : idx + 1'b1;
          state <= (last || step_mode) ? ST_IDLE : ST_REQ;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDX_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    LW'(idx) < seq_len);  // R2
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_gnt && !seq_wr |=> $stable(conv_ch));  // R11
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WAIT |-> !conv_req);  // R11
  AST_AUTO_IGNORES_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE && auto_mode && !reg_pass_done && !sw_start && !seq_wr
    |=> state == ST_IDLE);  // R6
endmodule

// File: rtl/inj_fmt.sv
module inj_fmt #(
  parameter int RAW_W = 12,
  parameter int OUT_W = 16,
  localparam int SH   = OUT_W - RAW_W - 1
) (
  input  logic [RAW_W-1:0] raw,
  input  logic [RAW_W-1:0] ofs,
  input  logic             left_just,
  output logic [OUT_W-1:0] val
);
  logic signed [RAW_W:0] diff;

  assign diff = $signed({1'b0, raw}) - $signed({1'b0, ofs});
  assign val  = left_just ? {diff, {SH{1'b0}}}
                          : {{SH{diff[RAW_W]}}, diff};
endmodule

// File: rtl/inj_group_ctrl.sv
module inj_group_ctrl
  import inj_pkg::*;
#(
  parameter int CH_W  = 5,
  parameter int SLOTS = 4,
  parameter int RAW_W = 12,
  parameter int OUT_W = 16,
  parameter int AW    = 4,
  parameter int DW    = 32,
  localparam int LW   = $clog2(SLOTS) + 1,
  localparam int IW   = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  input  logic             ext_trig,
  input  logic             reg_busy,
  input  logic             reg_pass_done,
  output logic             conv_req,
  output logic [CH_W-1:0]  conv_ch,
  input  logic             conv_gnt,
  input  logic             res_valid,
  input  logic [RAW_W-1:0] res_data,
  output logic             inj_eoc,
  output logic             inj_irq
);
  logic                   auto_mode, step_mode, irq_en, left_just, sw_start;
  logic                   seq_wr, sw_clr, res_we, eoc_set;
  logic [LW-1:0]          seq_len;
  logic [SLOTS*CH_W-1:0]  slots;
  logic [SLOTS*RAW_W-1:0] ofs_flat;
  logic [IW-1:0]          res_sel;
  logic [OUT_W-1:0]       res_val;

  inj_regs #(.CH_W(CH_W), .SLOTS(SLOTS), .RAW_W(RAW_W), .OUT_W(OUT_W),
             .AW(AW), .DW(DW)) u_regs (
    .clk, .rst_n, .wr_en(cfg_wr_en), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .auto_mode, .step_mode, .irq_en, .left_just, .sw_start,
    .seq_len, .slots, .ofs_flat, .seq_wr, .eoc(inj_eoc), .sw_clr, .res_we,
    .res_sel, .res_val, .eoc_set);

  inj_seq #(.CH_W(CH_W), .SLOTS(SLOTS)) u_seq (
    .clk, .rst_n, .auto_mode, .step_mode, .sw_start, .ext_trig, .reg_pass_done,
    .reg_busy, .seq_len, .slots, .seq_wr, .conv_req, .conv_ch, .conv_gnt,
    .res_valid, .res_we, .res_sel, .sw_clr, .eoc_set);

  inj_fmt #(.RAW_W(RAW_W), .OUT_W(OUT_W)) u_fmt (
    .raw(res_data), .ofs(ofs_flat[res_sel*RAW_W +: RAW_W]),
    .left_just, .val(res_val));

  assign inj_irq = inj_eoc & irq_en;

  AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_busy |-> !conv_req);  // R10
endmodule

// File: tb/sim_inj_group_ctrl.sv
module sim_inj_group_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ext_trig = 1'b0, reg_busy = 1'b0, reg_pass_done = 1'b0;
  logic        conv_req, conv_gnt = 1'b1;
  logic [4:0]  conv_ch;
  logic        res_valid = 1'b0;
  logic [11:0] res_data = '0;
  logic        inj_eoc, inj_irq;

  int n_chk = 0, n_err = 0, gcnt = 0, cnt = 0;
  int glog [64];
  logic [4:0] chq = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inj_group_ctrl u0 (.*);

  function automatic int raw_of(int ch);
    return ch * 120 + 5;
  endfunction

  // converter model: result three cycles after grant
  always @(posedge clk) begin
    res_valid <= 1'b0;
    if (conv_req && conv_gnt) begin
      glog[gcnt % 64] = conv_ch;
      gcnt = gcnt + 1;
    end
    if (!rst_n) cnt <= 0;
    else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        res_valid <= 1'b1;
        res_data  <= 12'(raw_of(int'(chq)));
      end
    end else if (conv_req && conv_gnt) begin
      chq <= conv_ch;
      cnt <= 3;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_addr = 4'(a); cfg_wdata = 32'(d); cfg_wr_en = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    cfg_addr = 4'(a);
    #1 v = int'(cfg_rdata);
  endtask

  task automatic trig();
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
  endtask

  task automatic wait_eoc(string req);
    int i;
    for (i = 0; i < 300 && !inj_eoc; i++) @(negedge clk);
    chk({req, " completion flag"}, int'(inj_eoc), 1);
  endtask

  function automatic int grp(int n, int c1, int c2, int c3, int c4);
    int ch[4] = '{c1, c2, c3, c4};
    int w = n << 20;
    for (int p = 0; p < n; p++) w |= ch[p] << ((4 - n + p) * 5);
    return w;
  endfunction

  task automatic t_reset();
    int v;
    rd(0, v); chk("R1 reset ctrl", v, 0);
    rd(1, v); chk("R8 reset flag", v, 0);
    rd(2, v); chk("R1 reset group", v, 32'h0010_0000);
    rd(8, v); chk("R3 reset result", v, 0);
    chk("R8 reset irq", int'(inj_irq), 0);
  endtask

  task automatic t_len_reject();
    int v;
    wr(2, grp(3, 7, 2, 12, 0));
    wr(2, 0 << 20 | 5'h1F);
    rd(2, v); chk("R1 length 0 rejected", v, grp(3, 7, 2, 12, 0));
    wr(2, (5 << 20) | 5'h1F);
    rd(2, v); chk("R1 length 5 rejected", v, grp(3, 7, 2, 12, 0));
  endtask

  task automatic t_group3();
    int v, g0;
    wr(3, 100); wr(4, 500); wr(5, 0); wr(6, 40);
    g0 = gcnt;
    trig(); wait_eoc("R8 group3");
    chk("R2 grants", gcnt - g0, 3);
    chk("R2 first ch", glog[g0 % 64], 7);
    chk("R2 second ch", glog[(g0 + 1) % 64], 2);
    chk("R2 last ch slot4", glog[(g0 + 2) % 64], 12);
    rd(8, v);  chk("R3 R4 result1", v, 745);
    rd(9, v);  chk("R4 negative result2", v, (245 - 500) & 16'hFFFF);
    rd(10, v); chk("R3 result3", v, 1445);
    rd(11, v); chk("R3 result4 untouched", v, 0);
    chk("R8 irq disabled", int'(inj_irq), 0);
  endtask

  task automatic t_left_irq();
    int v;
    wr(1, 1); chk("R8 flag cleared", int'(inj_eoc), 0);
    wr(0, 32'h0C);
    trig(); wait_eoc("R8 left");
    chk("R8 irq enabled", int'(inj_irq), 1);
    rd(8, v); chk("R5 left result1", v, (745 * 8) & 16'hFFFF);
    rd(9, v); chk("R5 left negative", v, (-255 * 8) & 16'hFFFF);
    cyc(5); chk("R8 flag holds", int'(inj_eoc), 1);
    wr(1, 1); chk("R8 irq clears", int'(inj_irq), 0);
    wr(0, 0);
  endtask

  task automatic t_len4_len1();
    int v, g0;
    wr(2, grp(4, 3, 9, 17, 31));
    g0 = gcnt;
    trig(); wait_eoc("R8 len4");
    chk("R2 len4 grants", gcnt - g0, 4);
    chk("R2 len4 ch1", glog[g0 % 64], 3);
    chk("R2 len4 ch4", glog[(g0 + 3) % 64], 31);
    rd(11, v); chk("R3 len4 result4", v, 3725 - 40);
    rd(9, v);  chk("R3 len4 result2", v, 1085 - 500);
    wr(1, 1);
    wr(2, grp(1, 21, 0, 0, 0));
    g0 = gcnt;
    trig(); wait_eoc("R8 len1");
    chk("R2 len1 channel", glog[g0 % 64], 21);
    rd(8, v); chk("R3 len1 result1", v, raw_of(21) - 100);
    rd(11, v); chk("R3 len1 result4 kept", v, 3685);
    wr(1, 1);
    wr(2, grp(3, 7, 2, 12, 0));
  endtask

  task automatic t_busy_hold();
    int g0 = gcnt;
    @(negedge clk) reg_busy = 1'b1;
    trig(); cyc(6);
    chk("R10 no req while busy", int'(conv_req), 0);
    chk("R10 no grant while busy", gcnt - g0, 0);
    @(negedge clk) reg_busy = 1'b0;
    #1 chk("R10 req after busy", int'(conv_req), 1);
    wait_eoc("R10 held start");
    wr(1, 1);
  endtask

  task automatic t_gnt_stall();
    @(negedge clk) conv_gnt = 1'b0;
    trig(); cyc(4);
    chk("R11 req waiting", int'(conv_req), 1);
    chk("R11 ch held", int'(conv_ch), 7);
    cyc(3);
    chk("R11 ch still held", int'(conv_ch), 7);
    @(negedge clk) conv_gnt = 1'b1;
    cyc(2);
    chk("R11 no req while outstanding", int'(conv_req), 0);
    wait_eoc("R11 stall");
    wr(1, 1);
  endtask

  task automatic t_retrigger();
    int g0 = gcnt;
    trig(); cyc(3); trig(); cyc(2); trig();
    wait_eoc("R12 retrig"); cyc(30);
    chk("R12 exactly N grants", gcnt - g0, 3);
    wr(1, 1);
  endtask

  task automatic t_step();
    int g0;
    wr(0, 32'h02);
    g0 = gcnt;
    trig(); cyc(10);
    chk("R7 one grant", gcnt - g0, 1);
    chk("R7 first ch", glog[g0 % 64], 7);
    chk("R8 flag not yet", int'(inj_eoc), 0);
    trig(); cyc(10);
    chk("R7 second ch", glog[(g0 + 1) % 64], 2);
    chk("R8 flag not yet 2", int'(inj_eoc), 0);
    trig(); cyc(10);
    chk("R7 third ch", glog[(g0 + 2) % 64], 12);
    chk("R8 flag after last step", int'(inj_eoc), 1);
    trig(); cyc(10);
    chk("R7 wrap to first", glog[(g0 + 3) % 64], 7);
    chk("R7 total grants", gcnt - g0, 4);
    wr(0, 0);
    wr(2, grp(3, 7, 2, 12, 0));
    wr(1, 1);
  endtask

  task automatic t_auto();
    int g0;
    wr(0, 32'h01);
    g0 = gcnt;
    trig(); cyc(15);
    chk("R6 trigger ignored", gcnt - g0, 0);
    chk("R6 no flag", int'(inj_eoc), 0);
    @(negedge clk) reg_pass_done = 1'b1;
    @(negedge clk) reg_pass_done = 1'b0;
    wait_eoc("R6 auto");
    chk("R6 auto grants", gcnt - g0, 3);
    wr(0, 0); wr(1, 1);
  endtask

  task automatic t_sw();
    int v;
    @(negedge clk) reg_busy = 1'b1;
    wr(0, 32'h10); cyc(4);
    rd(0, v); chk("R9 sw bit pending", (v >> 4) & 1, 1);
    @(negedge clk) reg_busy = 1'b0;
    cyc(3);
    rd(0, v); chk("R9 sw bit cleared", (v >> 4) & 1, 0);
    wait_eoc("R9 sw start");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    cyc(3);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_len_reject();
    t_group3();
    t_left_irq();
    t_len4_len1();
    t_busy_hold();
    t_gnt_stall();
    t_retrigger();
    t_step();
    t_auto();
    t_sw();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule